// File: doc/BRIEF.md
# Margin-Bounded Waveform Generator

This block drives a 12-bit output code that sweeps back and forth between two programmable limits, a lower bound and an upper bound. Three shapes are available: a triangle, a rising sawtooth and a falling sawtooth. The size of each code change comes from a 3-bit step-size selector, and the time between changes comes from a period selector that counts pulses of an external timebase tick. The repetition rate therefore follows from the distance between the limits, the step size and the period.

Generation is started and stopped by edges on a software run bit or on a general-purpose input pin. The pin is honoured only while its enable input is high. While stopped, the code keeps its last value. Each start reloads the code from the shape's starting limit. A running flag reports whether the code is currently being swept.

Top module: `wavegen`

## Requirements
- R1: While reset is asserted and just after it is released, `code` is 0 and `running` is 0.
- R2: `shape_sel` encodes the shape: 3'b000 triangle, 3'b001 rising sawtooth, 3'b010 falling sawtooth. Every other value (3'b011 to 3'b111, sine 3'b100 included) disables generation: `running` stays 0 and `code` holds.
- R3: `step_sel` sets the code change per step: 0→1, 1→2, 2→3, 3→4, 4→6, 5→8, 6→16, 7→32.
- R4: While running, one step is taken on every (`period_sel`+1)-th clock edge on which `tick` is high, counted from the start. With `tick` low the code does not change.
- R5: Triangle: the code rises by the step, clamps exactly at `hi_code`, then falls by the step and clamps exactly at `lo_code`, repeating. Each limit is output once per turn.
- R6: Rising sawtooth: the code rises by the step and clamps at `hi_code`. On the step after reaching `hi_code` it returns to `lo_code` in one step.
- R7: Falling sawtooth: the code falls by the step and clamps at `lo_code`. On the step after reaching `lo_code` it returns to `hi_code` in one step.
- R8: A start event is a rising edge of `run_bit`, or a rising edge of `gpio_in` while `gpio_en` is 1. On the clock edge that samples it, `running` rises and `code` loads `lo_code` (triangle and rising sawtooth) or `hi_code` (falling sawtooth). No step is taken on that edge.
- R9: A stop event is a falling edge of `run_bit`, or a falling edge of `gpio_in` while `gpio_en` is 1. On the clock edge that samples it, `running` falls and `code` keeps its value. A stop takes priority over a start seen on the same edge.
- R10: Edges on `gpio_in` while `gpio_en` is 0 neither start nor stop generation.
- R11: The clamping is exact at the ends of the code range: a rise past 4095 and a fall below 0 land on the limit without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| shape_sel | input | 3 | Waveform shape selector |
| step_sel | input | 3 | Code step size selector |
| period_sel | input | 4 | Ticks per step minus one |
| lo_code | input | 12 | Lower limit of the sweep |
| hi_code | input | 12 | Upper limit of the sweep (at least `lo_code`) |
| run_bit | input | 1 | Software start/stop level, acted on at its edges |
| gpio_in | input | 1 | Pin start/stop level, acted on at its edges |
| gpio_en | input | 1 | Allows `gpio_in` edges to act |
| code | output | 12 | Generated code |
| running | output | 1 | High while a valid shape is being generated |

## Verification
A table of eight configurations covers each shape with several step sizes. It includes narrow and wide spans, limits equal to each other and limits at the top and bottom of the code range. Eight consecutive codes are checked for each configuration, which separates the turn-around rule of the triangle from the wrap of the two sawtooths and shows exact clamping at both limits. Directed sequences then slow the step with the period selector and gate the tick. They also start and stop through the pin with its enable low and high, apply the disabling selector values, and give the same edge a stop on one source and a start on the other.

// File: rtl/wavegen.sv
module wavegen #(
  parameter int CW = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    shape_sel,
  input  logic [2:0]    step_sel,
  input  logic [SW-1:0] period_sel,
  input  logic [CW-1:0] lo_code,
  input  logic [CW-1:0] hi_code,
  input  logic          run_bit,
  input  logic          gpio_in,
  input  logic          gpio_en,
  output logic [CW-1:0] code,
  output logic          running
);

  localparam logic [2:0] SH_TRI = 3'b000;
  localparam logic [2:0] SH_SAW = 3'b001;
  localparam logic [2:0] SH_INV = 3'b010;

  logic          run_q, dir_dn, rb_q, gp_q;
  logic [SW-1:0] tcnt;
  logic [CW-1:0] code_q;
  logic [CW:0]   stp, up_sum, lo_plus;
  logic [CW-1:0] up_val, dn_val, nxt;
  logic          shape_ok, start_evt, stop_evt, go, stop_wins, step_now, tick_due;

  assign shape_ok  = (shape_sel == SH_TRI) || (shape_sel == SH_SAW) || (shape_sel == SH_INV);
  assign start_evt = (run_bit & ~rb_q) | (gpio_en & gpio_in & ~gp_q);
  assign stop_evt  = (~run_bit & rb_q) | (gpio_en & ~gpio_in & gp_q);
  assign go        = start_evt & ~stop_evt;
  assign stop_wins = stop_evt;
  assign tick_due  = tick && (tcnt == period_sel);
  assign step_now  = run_q && shape_ok && tick_due && !start_evt && !stop_evt;

  always_comb begin
    case (step_sel)
      3'd0:    stp = (CW+1)'(1);
      3'd1:    stp = (CW+1)'(2);
      3'd2:    stp = (CW+1)'(3);
      3'd3:    stp = (CW+1)'(4);
      3'd4:    stp = (CW+1)'(6);
      3'd5:    stp = (CW+1)'(8);
      3'd6:    stp = (CW+1)'(16);
      default: stp = (CW+1)'(32);
    endcase
  end

  assign up_sum  = {1'b0, code_q} + stp;
  assign lo_plus = {1'b0, lo_code} + stp;
  assign up_val  = (up_sum >= {1'b0, hi_code}) ? hi_code : up_sum[CW-1:0];
  assign dn_val  = ({1'b0, code_q} <= lo_plus) ? lo_code : (code_q - stp[CW-1:0]);

  always_comb begin
    case (shape_sel)
      SH_TRI:  nxt = dir_dn ? dn_val : up_val;
      SH_SAW:  nxt = (code_q >= hi_code) ? lo_code : up_val;
      SH_INV:  nxt = (code_q <= lo_code) ? hi_code : dn_val;
      default: nxt = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= 1'b0;
      gp_q <= 1'b0;
    end else begin
      rb_q <= run_bit;
      gp_q <= gpio_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      dir_dn <= 1'b0;
      tcnt   <= '0;
      code_q <= '0;
    end else if (stop_wins) begin
      run_q <= 1'b0;
    end else if (go) begin
      run_q  <= 1'b1;
      dir_dn <= 1'b0;
      tcnt   <= '0;
      if (shape_ok)
        code_q <= (shape_sel == SH_INV) ? hi_code : lo_code;
    end else if (run_q && shape_ok && tick) begin
      tcnt <= tick_due ? '0 : tcnt + 1'b1;
      if (step_now) begin
        code_q <= nxt;
        if (shape_sel == SH_TRI) begin
          if (!dir_dn && up_val == hi_code) dir_dn <= 1'b1;
          if (dir_dn && dn_val == lo_code)  dir_dn <= 1'b0;
        end
      end
    end
  end

  assign code    = code_q;
  assign running = run_q & shape_ok;

endmodule

// File: rtl/wavegen_chk.sv
module wavegen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [2:0]    shape_sel,
  input logic [CW-1:0] lo_code,
  input logic [CW-1:0] hi_code,
  input logic [CW-1:0] code,
  input logic          running,
  input logic          start_evt,
  input logic          stop_evt
);

  // R2
  shape_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (shape_sel <= 3'd2));

  // R5
  in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && lo_code <= hi_code) |-> (code >= lo_code && code <= hi_code));

  // R8
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !stop_evt && shape_sel <= 3'd2) |=>
      (running && code == $past(shape_sel == 3'b010 ? hi_code : lo_code)));

  // R9
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !running);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_evt) |=> $stable(code));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start_evt) |=> $stable(code));

endmodule

bind wavegen wavegen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .shape_sel(shape_sel),
  .lo_code(lo_code), .hi_code(hi_code), .code(code), .running(running),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/wavegen_bench.sv
`timescale 1ns/1ps
module wavegen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  shape_sel = 3'b000;
  logic [2:0]  step_sel = 3'd0;
  logic [3:0]  period_sel = 4'd0;
  logic [11:0] lo_code = 12'd0;
  logic [11:0] hi_code = 12'd0;
  logic        run_bit = 1'b0;
  logic        gpio_in = 1'b0;
  logic        gpio_en = 1'b0;
  logic [11:0] code;
  logic        running;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wavegen u_wavegen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shape_sel(shape_sel),
    .step_sel(step_sel), .period_sel(period_sel), .lo_code(lo_code),
    .hi_code(hi_code), .run_bit(run_bit), .gpio_in(gpio_in),
    .gpio_en(gpio_en), .code(code), .running(running)
  );

  localparam logic [2:0]  VF [8] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd0, 3'd1, 3'd2, 3'd0};
  localparam logic [2:0]  VS [8] = '{3'd0, 3'd3, 3'd1, 3'd2, 3'd7, 3'd6, 3'd4, 3'd5};
  localparam logic [11:0] VL [8] = '{12'd10, 12'd0, 12'd5, 12'd100, 12'd4000, 12'd4090, 12'd0, 12'd50};
  localparam logic [11:0] VH [8] = '{12'd13, 12'd10, 12'd10, 12'd107, 12'd4095, 12'd4095, 12'd13, 12'd50};
  localparam logic [11:0] EXP [8][8] = '{
    '{12'd10, 12'd11, 12'd12, 12'd13, 12'd12, 12'd11, 12'd10, 12'd11},
    '{12'd0, 12'd4, 12'd8, 12'd10, 12'd6, 12'd2, 12'd0, 12'd4},
    '{12'd5, 12'd7, 12'd9, 12'd10, 12'd5, 12'd7, 12'd9, 12'd10},
    '{12'd107, 12'd104, 12'd101, 12'd100, 12'd107, 12'd104, 12'd101, 12'd100},
    '{12'd4000, 12'd4032, 12'd4064, 12'd4095, 12'd4063, 12'd4031, 12'd4000, 12'd4032},
    '{12'd4090, 12'd4095, 12'd4090, 12'd4095, 12'd4090, 12'd4095, 12'd4090, 12'd4095},
    '{12'd13, 12'd7, 12'd1, 12'd0, 12'd13, 12'd7, 12'd1, 12'd0},
    '{12'd50, 12'd50, 12'd50, 12'd50, 12'd50, 12'd50, 12'd50, 12'd50}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code in reset", code, 0);
    chk("R1 running in reset", running, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after reset", code, 0);
    chk("R1 running after reset", running, 0);

    // R5 R6 R7 R3 R11: shape table
    tick = 1'b1;
    for (int i = 0; i < 8; i++) begin
      shape_sel = VF[i];
      step_sel  = VS[i];
      lo_code   = VL[i];
      hi_code   = VH[i];
      @(negedge clk);
      run_bit = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk($sformatf("R5/R6/R7 vec%0d code%0d", i, k), code, EXP[i][k]);
        chk($sformatf("R8 vec%0d running", i), running, 1);
      end
      run_bit = 1'b0;
      @(negedge clk);
      chk($sformatf("R9 vec%0d stopped", i), running, 0);
      @(negedge clk);
      chk($sformatf("R9 vec%0d hold", i), code, EXP[i][7]);
    end

    // R4: period selector and tick gating
    shape_sel = 3'b000; step_sel = 3'd0; lo_code = 12'd0; hi_code = 12'd100;
    period_sel = 4'd2;
    run_bit = 1'b1;
    @(negedge clk); chk("R4 start code", code, 0);
    @(negedge clk); chk("R4 tick1 no step", code, 0);
    @(negedge clk); chk("R4 tick2 no step", code, 0);
    @(negedge clk); chk("R4 tick3 step", code, 1);
    tick = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 no tick holds", code, 1);
    tick = 1'b1;
    run_bit = 1'b0;
    @(negedge clk);
    chk("R9 stop after slew", running, 0);
    period_sel = 4'd0;

    // R10: pin ignored when disabled
    gpio_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pin disabled running", running, 0);
    chk("R10 pin disabled code", code, 1);
    gpio_in = 1'b0;
    @(negedge clk);

    // R8 R9: pin start and stop
    gpio_en = 1'b1;
    shape_sel = 3'b010; lo_code = 12'd20; hi_code = 12'd30;
    @(negedge clk);
    gpio_in = 1'b1;
    @(negedge clk);
    chk("R8 pin start loads high limit", code, 30);
    chk("R8 pin start running", running, 1);
    @(negedge clk);
    chk("R7 pin run step", code, 29);
    gpio_in = 1'b0;
    @(negedge clk);
    chk("R9 pin stop running", running, 0);
    chk("R9 pin stop holds", code, 29);

    // R2: disabling selector values
    for (int s = 3; s < 8; s++) begin
      shape_sel = 3'(s);
      run_bit = 1'b1;
      repeat (3) @(negedge clk);
      chk($sformatf("R2 sel %0d running", s), running, 0);
      chk($sformatf("R2 sel %0d code holds", s), code, 29);
      run_bit = 1'b0;
      @(negedge clk);
    end

    // R8: restart from low limit, sawtooth step 8
    shape_sel = 3'b001; step_sel = 3'd5;
    @(negedge clk);
    run_bit = 1'b1;
    @(negedge clk); chk("R8 restart low limit", code, 20);
    @(negedge clk); chk("R6 saw step", code, 28);
    @(negedge clk); chk("R6 saw clamp", code, 30);
    @(negedge clk); chk("R6 saw wrap", code, 20);

    // R9: stop on run_bit and start on pin in the same cycle
    run_bit = 1'b0;
    gpio_in = 1'b1;
    @(negedge clk);
    chk("R9 stop wins running", running, 0);
    chk("R9 stop wins code", code, 20);
    gpio_in = 1'b0;
    @(negedge clk);
    chk("R9 pin fall keeps stopped", running, 0);

    // R1: reset during a run
    run_bit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    run_bit = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset code", code, 0);
    chk("R1 mid-run reset running", running, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", running, 0);

    finish_run();
  end
endmodule